// File: doc/BRIEF.md
# Three-Field Register Processor Core

A small multi-cycle processor that runs 32-bit instructions from a word-addressed memory. The memory sits on a shared bus with an address, a bidirectional data path, an enable, and a read/not-write line. The core keeps a program counter, a zero flag and a register file of 32 words. Register 0 always reads as zero.

Every instruction takes three cycles. In the first cycle the core presents the fetch address. In the second cycle it captures the word, which the memory registers one clock late. In the third cycle it decodes and executes. The core loads 16-bit immediates, adds and subtracts registers, and takes absolute jumps, either conditional on the zero flag or always. A halt instruction parks the bus and raises a status output.

A combinational debug read port makes any register visible at the block's pins, so the results of a program can be read once it has halted.

Top module: `tri_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `halted` is 0, `mem_en` is 1, `mem_rd_nwr` is 1 and `mem_addr` is 0. Reset also clears every register to zero.
- R2: Each instruction takes exactly three cycles. `mem_addr` holds the same fetch address for two cycles with `mem_en` high, and `mem_en` is low in the third cycle. With no jump, the next fetch address is one word higher. `mem_rd_nwr` is never driven low.
- R3: Opcode bits 31:26 = 001111 writes bits 15:0, zero-extended to 32 bits, into the register named by bits 25:21.
- R4: Opcode 000100 writes the sum, modulo 2^32, of the register named by bits 20:16 and the register named by bits 15:11 into the register named by bits 25:21.
- R5: Opcode 000101 writes the register named by bits 20:16 minus the register named by bits 15:11, modulo 2^32, into the register named by bits 25:21.
- R6: Only opcodes 000100 and 000101 update the zero flag. The flag is set exactly when their 32-bit result is zero. All other instructions leave it unchanged.
- R7: Opcode 001100 makes the next fetch address bits 7:0 of the instruction when the zero flag is set. When the flag is clear, the next fetch address is the following word.
- R8: Opcode 001110 always makes the next fetch address bits 7:0 of the instruction.
- R9: Opcode 111111 raises `halted`. While `halted` is high, `mem_en` is 0 and `mem_addr` holds the address of the halt instruction. This lasts until the next reset.
- R10: Register 0 reads as zero on the debug port and as an operand. Writes to register 0 have no effect.
- R11: Any other opcode, including the all-zero word, changes no register and no flag, and execution moves on to the next word.
- R12: The memory preload runs 5 times 6 by repeated addition. `halted` rises 90 cycles after reset is released, and register 3 then reads 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | ADDR_W (8) | Word address of the memory access |
| mem_data | inout | 32 | Shared data bus; the core only samples it |
| mem_en | output | 1 | Memory access enable |
| mem_rd_nwr | output | 1 | 1 for read, 0 for write |
| halted | output | 1 | High once a halt instruction has executed |
| dbg_sel | input | 5 | Register index for the debug read port |
| dbg_val | output | 32 | Combinational value of the selected register |

## Verification
Let cycle 0 be the first cycle after reset is released. Instruction k of a straight-line stretch then shows its address in cycles 3k and 3k+1, and `mem_en` is low in cycle 3k+2. The bench samples one time unit after each falling edge and compares against that schedule. `halted` is due exactly three cycles per executed instruction after release: cycle 90 for the preload and cycle 39 for the corner-case program. The bench counts falling edges from release and compares the count exactly. Register results are read through the debug port only after `halted` has been seen, and the halt conditions are checked again 20 cycles later.

// File: rtl/tri_core_pkg.sv
package tri_core_pkg;

    localparam int unsigned WORD_W    = 32;
    localparam int unsigned OPC_W     = 6;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned IMM_W     = 16;

    localparam logic [OPC_W-1:0] OP_LDI  = 6'b001111;
    localparam logic [OPC_W-1:0] OP_ADD  = 6'b000100;
    localparam logic [OPC_W-1:0] OP_SUB  = 6'b000101;
    localparam logic [OPC_W-1:0] OP_JZ   = 6'b001100;
    localparam logic [OPC_W-1:0] OP_JMP  = 6'b001110;
    localparam logic [OPC_W-1:0] OP_HALT = 6'b111111;

    typedef enum logic [1:0] {
        ST_FADDR = 2'd0,
        ST_FWAIT = 2'd1,
        ST_EXEC  = 2'd2,
        ST_HALT  = 2'd3
    } state_e;

    typedef struct packed {
        logic                 wr_en;
        logic                 use_imm;
        logic                 do_sub;
        logic                 set_zf;
        logic                 jump;
        logic                 jump_z;
        logic                 halt;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] rs;
        logic [REG_IDX_W-1:0] rt;
        logic [IMM_W-1:0]     imm;
    } dec_s;

endpackage

// File: rtl/tri_core_decode.sv
module tri_core_decode
    import tri_core_pkg::*;
(
    input  logic [WORD_W-1:0] instr,
    output dec_s              dec
);
    logic [OPC_W-1:0] opc;

    assign opc = instr[31:26];

    always_comb begin
        dec         = '0;
        dec.rd      = instr[25:21];
        dec.rs      = instr[20:16];
        dec.rt      = instr[15:11];
        dec.imm     = instr[15:0];
        case (opc)
            OP_LDI: begin
                dec.wr_en   = 1'b1;
                dec.use_imm = 1'b1;
            end
            OP_ADD: begin
                dec.wr_en  = 1'b1;
                dec.set_zf = 1'b1;
            end
            OP_SUB: begin
                dec.wr_en  = 1'b1;
                dec.do_sub = 1'b1;
                dec.set_zf = 1'b1;
            end
            OP_JZ:   dec.jump_z = 1'b1;
            OP_JMP:  dec.jump   = 1'b1;
            OP_HALT: dec.halt   = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/tri_core_alu.sv
module tri_core_alu #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          do_sub,
    output logic [DW-1:0] result,
    output logic          zero
);
    always_comb begin
        if (do_sub) begin
            result = a - b;
        end else begin
            result = a + b;
        end
        zero = (result == '0);
    end
endmodule

// File: rtl/tri_core_regfile.sv
module tri_core_regfile #(
    parameter int unsigned DW    = 32,
    parameter int unsigned CNT   = 32,
    parameter int unsigned PORTS = 3,
    localparam int unsigned IW   = $clog2(CNT)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we,
    input  logic [IW-1:0]              waddr,
    input  logic [DW-1:0]              wdata,
    input  logic [PORTS-1:0][IW-1:0]   rd_idx,
    output logic [PORTS-1:0][DW-1:0]   rd_val
);
    logic [DW-1:0] regs_d [CNT];
    logic [DW-1:0] regs_q [CNT];

    always_comb begin
        for (int i = 0; i < int'(CNT); i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we && (waddr != '0)) begin
            regs_d[waddr] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(CNT); i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(CNT); i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar p = 0; p < int'(PORTS); p++) begin : g_rport
        assign rd_val[p] = regs_q[rd_idx[p]];
    end
endmodule

// File: rtl/tri_core.sv
module tri_core
    import tri_core_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned REG_CNT = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    output logic [ADDR_W-1:0]    mem_addr,
    inout  wire  [WORD_W-1:0]    mem_data,
    output logic                 mem_en,
    output logic                 mem_rd_nwr,
    output logic                 halted,
    input  logic [REG_IDX_W-1:0] dbg_sel,
    output logic [WORD_W-1:0]    dbg_val
);
    localparam int unsigned IW = $clog2(REG_CNT);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] ir;
        logic              zf;
    } core_s;

    core_s cur_q;
    core_s cur_d;

    dec_s                    dec;
    logic [2:0][IW-1:0]      rf_idx;
    logic [2:0][WORD_W-1:0]  rf_val;
    logic                    rf_we;
    logic [WORD_W-1:0]       rf_wdata;
    logic [WORD_W-1:0]       alu_res;
    logic                    alu_zero;
    logic [ADDR_W-1:0]       target;

    state_e                  state_w;
    logic                    zf_w;
    logic [OPC_W-1:0]        op_w;

    tri_core_decode u_dec (
        .instr (cur_q.ir),
        .dec   (dec)
    );

    assign rf_idx[0] = IW'(dec.rs);
    assign rf_idx[1] = IW'(dec.rt);
    assign rf_idx[2] = IW'(dbg_sel);

    tri_core_regfile #(
        .DW    (WORD_W),
        .CNT   (REG_CNT),
        .PORTS (3)
    ) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (IW'(dec.rd)),
        .wdata  (rf_wdata),
        .rd_idx (rf_idx),
        .rd_val (rf_val)
    );

    tri_core_alu #(
        .DW (WORD_W)
    ) u_alu (
        .a      (rf_val[0]),
        .b      (rf_val[1]),
        .do_sub (dec.do_sub),
        .result (alu_res),
        .zero   (alu_zero)
    );

    assign target = cur_q.ir[ADDR_W-1:0];

    always_comb begin
        cur_d    = cur_q;
        rf_we    = 1'b0;
        rf_wdata = dec.use_imm ? {{(WORD_W-IMM_W){1'b0}}, dec.imm} : alu_res;
        mem_en   = 1'b0;
        case (cur_q.st)
            ST_FADDR: begin
                mem_en   = 1'b1;
                cur_d.st = ST_FWAIT;
            end
            ST_FWAIT: begin
                mem_en   = 1'b1;
                cur_d.ir = mem_data;
                cur_d.st = ST_EXEC;
            end
            ST_EXEC: begin
                if (dec.halt) begin
                    cur_d.st = ST_HALT;
                end else begin
                    cur_d.st = ST_FADDR;
                    rf_we    = dec.wr_en;
                    if (dec.set_zf) begin
                        cur_d.zf = alu_zero;
                    end
                    if (dec.jump || (dec.jump_z && cur_q.zf)) begin
                        cur_d.pc = target;
                    end else begin
                        cur_d.pc = cur_q.pc + 1'b1;
                    end
                end
            end
            default: cur_d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_FADDR, pc: '0, ir: '0, zf: 1'b0};
        end else begin
            cur_q <= cur_d;
        end
    end

    assign mem_addr   = cur_q.pc;
    assign mem_rd_nwr = 1'b1;
    assign halted     = (cur_q.st == ST_HALT);
    assign dbg_val    = rf_val[2];

    assign state_w = cur_q.st;
    assign zf_w    = cur_q.zf;
    assign op_w    = cur_q.ir[31:26];
endmodule

// File: rtl/tri_core_checker.sv
module tri_core_checker
    import tri_core_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    mem_addr,
    input logic                 mem_en,
    input logic                 halted,
    input logic [REG_IDX_W-1:0] dbg_sel,
    input logic [WORD_W-1:0]    dbg_val,
    input state_e               st,
    input logic                 zf,
    input logic [OPC_W-1:0]     op
);
    AST_FETCH_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FWAIT) |-> ($past(st) == ST_FADDR && $stable(mem_addr))); // R2

    AST_SEQ_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FADDR && $past(st) == ST_EXEC && $past(op) != OP_JZ && $past(op) != OP_JMP)
        |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R2

    AST_ZF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zf) |-> ($past(st) == ST_EXEC && ($past(op) == OP_ADD || $past(op) == OP_SUB))); // R6

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALT_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_en); // R9

    AST_HALT_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(mem_addr)); // R9

    AST_REG0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_sel == '0) |-> (dbg_val == '0)); // R10
endmodule

bind tri_core tri_core_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_addr (mem_addr),
    .mem_en   (mem_en),
    .halted   (halted),
    .dbg_sel  (dbg_sel),
    .dbg_val  (dbg_val),
    .st       (state_w),
    .zf       (zf_w),
    .op       (op_w)
);

// File: tb/tri_core_bench.sv
module tri_core_bench;
    import tri_core_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int DEPTH      = 1 << AW;
    localparam int N_EXP      = 15;

    // {program select, register index, expected value}
    localparam logic [37:0] EXP_TAB [N_EXP] = '{
        {1'b0, 5'd0,  32'd0},
        {1'b0, 5'd1,  32'd5},
        {1'b0, 5'd2,  32'd6},
        {1'b0, 5'd3,  32'd30},
        {1'b0, 5'd4,  32'd1},
        {1'b0, 5'd5,  32'd0},
        {1'b1, 5'd0,  32'd0},
        {1'b1, 5'd7,  32'd3},
        {1'b1, 5'd9,  32'hFFFF_FFFE},
        {1'b1, 5'd10, 32'd0},
        {1'b1, 5'd11, 32'h0000_FFFF},
        {1'b1, 5'd12, 32'd0},
        {1'b1, 5'd13, 32'h0001_0002},
        {1'b1, 5'd14, 32'd3},
        {1'b1, 5'd15, 32'd0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [AW-1:0]        mem_addr;
    wire  [WORD_W-1:0]    mem_data;
    logic                 mem_en;
    logic                 mem_rd_nwr;
    logic                 halted;
    logic [REG_IDX_W-1:0] dbg_sel = '0;
    logic [WORD_W-1:0]    dbg_val;

    logic                 prog_sel = 1'b0;
    logic [WORD_W-1:0]    mem [DEPTH];
    logic [WORD_W-1:0]    rd_data;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tri_core #(.ADDR_W(AW), .REG_CNT(32)) u_tri_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_addr   (mem_addr),
        .mem_data   (mem_data),
        .mem_en     (mem_en),
        .mem_rd_nwr (mem_rd_nwr),
        .halted     (halted),
        .dbg_sel    (dbg_sel),
        .dbg_val    (dbg_val)
    );

    function automatic logic [31:0] enc_r(logic [5:0] op, int rd, int rs, int rt);
        return {op, 5'(rd), 5'(rs), 5'(rt), 11'd0};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rd, logic [15:0] imm);
        return {op, 5'(rd), 5'd0, imm};
    endfunction

    function automatic logic [31:0] enc_j(logic [5:0] op, int tgt);
        return {op, 26'(tgt)};
    endfunction

    function automatic logic [31:0] prog_word(logic sel, int a);
        if (!sel) begin
            case (a)
                1:  return enc_i(OP_LDI, 1, 16'd5);
                2:  return enc_i(OP_LDI, 2, 16'd6);
                3:  return enc_i(OP_LDI, 3, 16'd0);
                4:  return enc_i(OP_LDI, 4, 16'd1);
                5:  return enc_r(OP_ADD, 5, 0, 2);
                6:  return enc_r(OP_ADD, 3, 3, 1);
                7:  return enc_r(OP_SUB, 5, 5, 4);
                8:  return enc_j(OP_JZ, 10);
                9:  return enc_j(OP_JMP, 6);
                10: return enc_j(OP_HALT, 0);
                default: return '0;
            endcase
        end else begin
            case (a)
                0:  return enc_i(OP_LDI, 0, 16'd7);
                1:  return enc_i(OP_LDI, 7, 16'd3);
                2:  return enc_i(OP_LDI, 8, 16'd5);
                3:  return enc_r(OP_SUB, 9, 7, 8);
                4:  return enc_j(OP_JZ, 20);
                5:  return enc_r(OP_ADD, 10, 0, 0);
                6:  return enc_i(OP_LDI, 11, 16'hFFFF);
                7:  return enc_i(6'b000001, 15, 16'd9);
                8:  return enc_j(OP_JZ, 12);
                9:  return enc_i(OP_LDI, 12, 16'd1);
                10: return enc_j(OP_HALT, 0);
                12: return enc_r(OP_ADD, 13, 11, 7);
                13: return enc_r(OP_ADD, 14, 9, 8);
                14: return enc_j(OP_JMP, 10);
                20: return enc_i(OP_LDI, 12, 16'd2);
                21: return enc_j(OP_HALT, 0);
                default: return '0;
            endcase
        end
    endfunction

    // memory model: registered read, preload on reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= prog_word(prog_sel, i);
            end
            rd_data <= '0;
        end else if (!mem_rd_nwr && mem_en) begin
            mem[mem_addr] <= mem_data;
        end else begin
            rd_data <= mem[mem_addr];
        end
    end

    assign mem_data = mem_rd_nwr ? rd_data : 'z;

    function automatic string tag_of(int i);
        case (i)
            0, 6:           return "R10";
            1, 2, 4, 7, 10: return "R3";
            3:              return "R12";
            5, 8:           return "R5";
            9, 13:          return "R4";
            11:             return "R7";
            12:             return "R6";
            default:        return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_prog(input logic sel);
        int cyc;
        prog_sel = sel;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        chk("R1", 32'(halted), 32'd0);
        chk("R1", 32'(mem_addr), 32'd0);
        chk("R1", 32'(mem_en), 32'd1);
        chk("R1", 32'(mem_rd_nwr), 32'd1);
        dbg_sel = 5'd3;
        #1;
        chk("R1", dbg_val, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        cyc = 0;
        while (!halted && cyc < 400) begin
            if (!sel && cyc < 18) begin
                chk("R2", 32'(mem_en), ((cyc % 3) < 2) ? 32'd1 : 32'd0);
                chk("R2", 32'(mem_addr), 32'(cyc / 3));
                chk("R2", 32'(mem_rd_nwr), 32'd1);
            end
            @(negedge clk);
            #1;
            cyc++;
        end
        if (sel) chk("R8", 32'(cyc), 32'd39);
        else     chk("R12", 32'(cyc), 32'd90);
        repeat (20) @(negedge clk);
        #1;
        chk("R9", 32'(halted), 32'd1);
        chk("R9", 32'(mem_en), 32'd0);
        chk("R9", 32'(mem_addr), 32'd10);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected halt");
        $display("  [TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        logic [1:0] loaded;
        loaded = 2'b11;
        for (int i = 0; i < N_EXP; i++) begin
            if ({1'b0, EXP_TAB[i][37]} != loaded) begin
                run_prog(EXP_TAB[i][37]);
                loaded = {1'b0, EXP_TAB[i][37]};
            end
            dbg_sel = EXP_TAB[i][36:32];
            #1;
            chk(tag_of(i), dbg_val, EXP_TAB[i][31:0]);
        end
        // directed: reset in a halted state returns to the fetch of word 0
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk("R1", 32'(halted), 32'd0);
        chk("R1", 32'(mem_addr), 32'd0);
        dbg_sel = 5'd14;
        #1;
        chk("R1", dbg_val, 32'd0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule